// File: doc/BRIEF.md
# SPI Flash Command Engine

This block lets software run one serial flash transaction at a time through three 32-bit registers on a simple read/write bus. Software loads an opcode and a 24-bit flash address into the command register and, if needed, up to four payload bytes into the data register. It then writes the control register with a transmit byte count, a receive byte count and the start bit. The engine lowers chip select and shifts the transmit bytes out on MOSI in SPI mode 0. It then clocks in the receive bytes from MISO, packs them into the data register and raises chip select again. A busy flag in the control register stays set for the whole transaction, so software polls it before issuing the next command.

The engine is a four-state machine. `ST_IDLE` holds chip select high and SCK low. A start with a nonzero transmit count takes the *launch* transition to `ST_LOW`, which drives SCK low with MOSI stable. On each divider tick, `ST_LOW` takes the *rise* transition to `ST_HIGH` and MISO is sampled at that point. From `ST_HIGH` a tick takes the *fall* transition back to `ST_LOW`, with MOSI moving to the next bit. When the last bit has been clocked, a tick instead takes the *finish* transition to `ST_TRAIL`. `ST_TRAIL` waits one more half period and takes the *release* transition to `ST_IDLE`, where chip select goes high. A start with a zero transmit count leaves the machine in `ST_IDLE`.

Top module: `spi_cmd_engine`

## Requirements
- R1: Registers sit at byte address 0x00 (control), 0x04 (command) and 0x08 (data), and all three read as zero after reset. Control bits 3:0 (transmit count), 7:4 (receive count), 18:17 (size) and 25:24 (divider select) read back as written. Start (bit 8) and every other unlisted bit read as zero. In the command register, bits 7:0 are the opcode and bits 31:8 are the flash address.
- R2: Writing control with bit 8 set and a nonzero transmit count starts a transaction. Control bit 16 (busy) reads 1 from the next cycle and returns to 0 in the same cycle that chip select goes high.
- R3: The transmit byte order is: opcode, address bits 23:16, 15:8, 7:0, then data bits 7:0, 15:8, 23:16, 31:24. Transmit positions 8 and above send 0x00. Every byte goes out MSB first.
- R4: Receive bytes follow the transmit bytes. The first received byte lands in data bits 7:0, the second in 15:8, and so on. Bytes beyond the receive count read as zero, and received bytes after the fourth are discarded. MOSI is low while receiving. A receive count of zero leaves the data register unchanged.
- R5: SPI mode 0 is used. SCK is low whenever chip select is high. Chip select falls exactly once per transaction and stays low for exactly 8 x (transmit + receive) SCK rising edges.
- R6: Each SCK half period lasts 2^d clock cycles, where d is the divider select in control bits 25:24.
- R7: While busy, bus writes to any register are ignored, including a second start.
- R8: A start with a transmit count of zero never lowers chip select, never sets busy and leaves the data register unchanged.
- R9: After reset, chip select is high and SCK and MOSI are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench targets several corner cases, each with a distinct failure symptom:
- A transmit count above eight: a design that indexes past the frame sends stale register bytes instead of zeros.
- A receive count above four: a wrong design overwrites the data register or wraps bytes into it.
- A zero transmit count with start set: a wrong design pulses chip select or sticks busy.
- A second start and register writes while busy: a wrong design corrupts the command in flight or runs a second transaction.

A flash model on the pins serves a random bit stream, and every divider setting is checked by timing successive SCK rises. A swapped address byte order, a bit-order slip or an off-by-one in the bit counter shows up as a wrong byte, a wrong edge count or a misplaced received byte.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int WORD_W      = 32;
    localparam int CNT_W       = 4;
    localparam int TXN_LSB     = 0;
    localparam int RXN_LSB     = 4;
    localparam int GO_BIT      = 8;
    localparam int BUSY_BIT    = 16;
    localparam int SIZE_LSB    = 17;
    localparam int SIZE_W      = 2;
    localparam int DIV_LSB     = 24;
    localparam int FRAME_BYTES = 8;
    localparam int RX_SLOTS    = 4;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_CMD  = 8'h04;
    localparam logic [7:0] OFS_DATA = 8'h08;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL
    } eng_state_t;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              rx_we,
    input  logic [1:0]        rx_idx,
    input  logic [7:0]        rx_byte,
    output logic              launch,
    output logic [CNT_W-1:0]  launch_tx,
    output logic [CNT_W-1:0]  launch_rx,
    output logic [DIV_W-1:0]  div_sel,
    output logic [WORD_W-1:0] cmd_q,
    output logic [WORD_W-1:0] data_q
);
    logic [CNT_W-1:0]  txn_q, rxn_q;
    logic [SIZE_W-1:0] size_q;
    logic [DIV_W-1:0]  div_q;
    logic              hit_ctrl, hit_cmd, hit_data, wr_ok;

    assign hit_ctrl = (bus_addr == OFS_CTRL[ADDR_W-1:0]);
    assign hit_cmd  = (bus_addr == OFS_CMD[ADDR_W-1:0]);
    assign hit_data = (bus_addr == OFS_DATA[ADDR_W-1:0]);
    assign wr_ok    = bus_sel & bus_we & ~busy;

    assign launch    = wr_ok & hit_ctrl & bus_wdata[GO_BIT];
    assign launch_tx = bus_wdata[TXN_LSB +: CNT_W];
    assign launch_rx = bus_wdata[RXN_LSB +: CNT_W];
    assign div_sel   = div_q;

    logic unused_wbits;
    assign unused_wbits = ^{bus_wdata[WORD_W-1:DIV_LSB+DIV_W],
                            bus_wdata[DIV_LSB-1:SIZE_LSB+SIZE_W],
                            bus_wdata[SIZE_LSB-1:GO_BIT+1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txn_q  <= '0;
            rxn_q  <= '0;
            size_q <= '0;
            div_q  <= '0;
            cmd_q  <= '0;
        end else if (wr_ok) begin
            if (hit_ctrl) begin
                txn_q  <= bus_wdata[TXN_LSB +: CNT_W];
                rxn_q  <= bus_wdata[RXN_LSB +: CNT_W];
                size_q <= bus_wdata[SIZE_LSB +: SIZE_W];
                div_q  <= bus_wdata[DIV_LSB +: DIV_W];
            end
            if (hit_cmd) cmd_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_ok && hit_data) begin
            data_q <= bus_wdata;
        end else if (launch && launch_tx != '0 && launch_rx != '0) begin
            data_q <= '0;
        end else if (rx_we) begin
            data_q[{rx_idx, 3'b000} +: 8] <= rx_byte;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (hit_ctrl) begin
                bus_rdata[TXN_LSB +: CNT_W]   = txn_q;
                bus_rdata[RXN_LSB +: CNT_W]   = rxn_q;
                bus_rdata[BUSY_BIT]           = busy;
                bus_rdata[SIZE_LSB +: SIZE_W] = size_q;
                bus_rdata[DIV_LSB +: DIV_W]   = div_q;
            end else if (hit_cmd) begin
                bus_rdata = cmd_q;
            end else if (hit_data) begin
                bus_rdata = data_q;
            end
        end
    end

    // R7: a command write while busy leaves the command register untouched
    assert_busy_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && busy && hit_cmd) |=> $stable(cmd_q));

    // R7: a control write while busy leaves the counts untouched
    assert_busy_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && busy && hit_ctrl) |=> ($stable(txn_q) && $stable(rxn_q)));
endmodule

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] sel,
    output logic             tick
);
    localparam int SPAN_W = ((1 << DIV_W) - 1) < 1 ? 1 : ((1 << DIV_W) - 1);

    logic [SPAN_W-1:0] cnt_q, lim;

    assign lim  = ~({SPAN_W{1'b1}} << sel);
    assign tick = en && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || cnt_q == lim) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: with a divider above one, ticks never come back to back
    assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lim != '0 && $stable(sel)) |=> !tick);
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [CNT_W-1:0]  launch_tx,
    input  logic [CNT_W-1:0]  launch_rx,
    input  logic [WORD_W-1:0] snap_cmd,
    input  logic [WORD_W-1:0] snap_data,
    input  logic              tick,
    input  logic              spi_miso,
    output logic              busy,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    output logic              rx_we,
    output logic [1:0]        rx_idx,
    output logic [7:0]        rx_byte
);
    eng_state_t       state_q, state_d;
    logic [7:0]       frame_q   [FRAME_BYTES];
    logic [7:0]       frame_new [FRAME_BYTES];
    logic [CNT_W-1:0] txn_q;
    logic [7:0]       total_q, bit_q, bit_nx;
    logic [6:0]       acc_q;
    logic             cs_q, sck_q, mosi_q;
    logic             start_ok, last_bit, next_mosi, in_rx;
    logic [4:0]       byte_pos, rx_pos, nx_pos;

    assign start_ok = launch && (launch_tx != '0);
    assign busy     = (state_q != ST_IDLE);
    assign spi_cs_n = cs_q;
    assign spi_sck  = sck_q;
    assign spi_mosi = mosi_q;

    // frame assembly: opcode, address high to low, data low to high
    always_comb begin
        frame_new[0] = snap_cmd[7:0];
        for (int a = 1; a < 4; a++) frame_new[a] = snap_cmd[8*(4-a) +: 8];
        for (int d = 0; d < RX_SLOTS; d++) frame_new[4+d] = snap_data[8*d +: 8];
    end

    assign last_bit = (bit_q == total_q - 8'd1);
    assign bit_nx   = bit_q + 8'd1;
    assign nx_pos   = bit_nx[7:3];

    always_comb begin
        next_mosi = 1'b0;
        if (nx_pos < {1'b0, txn_q} && nx_pos < 5'(FRAME_BYTES))
            next_mosi = frame_q[nx_pos[2:0]][~bit_nx[2:0]];
    end

    assign byte_pos = bit_q[7:3];
    assign in_rx    = (byte_pos >= {1'b0, txn_q});
    assign rx_pos   = byte_pos - {1'b0, txn_q};
    assign rx_we    = (state_q == ST_LOW) && tick && in_rx &&
                      (bit_q[2:0] == 3'd7) && (rx_pos < 5'(RX_SLOTS));
    assign rx_idx   = rx_pos[1:0];
    assign rx_byte  = {acc_q, spi_miso};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_d = ST_LOW;
            ST_LOW:   if (tick) state_d = ST_HIGH;
            ST_HIGH:  if (tick) state_d = last_bit ? ST_TRAIL : ST_LOW;
            ST_TRAIL: if (tick) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q    <= 1'b1;
            sck_q   <= 1'b0;
            mosi_q  <= 1'b0;
            txn_q   <= '0;
            total_q <= '0;
            bit_q   <= '0;
            acc_q   <= '0;
            for (int f = 0; f < FRAME_BYTES; f++) frame_q[f] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        for (int f = 0; f < FRAME_BYTES; f++) frame_q[f] <= frame_new[f];
                        txn_q   <= launch_tx;
                        total_q <= ({4'b0, launch_tx} + {4'b0, launch_rx}) << 3;
                        bit_q   <= '0;
                        acc_q   <= '0;
                        cs_q    <= 1'b0;
                        sck_q   <= 1'b0;
                        mosi_q  <= snap_cmd[7];
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sck_q <= 1'b1;
                        acc_q <= {acc_q[5:0], spi_miso};
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sck_q <= 1'b0;
                        if (last_bit) begin
                            mosi_q <= 1'b0;
                        end else begin
                            bit_q  <= bit_nx;
                            mosi_q <= next_mosi;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) cs_q <= 1'b1;
                end
                default: cs_q <= 1'b1;
            endcase
        end
    end

    // R5: the serial clock rests low whenever the flash is deselected
    assert_idle_sck_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R5: the bit counter never runs past the programmed length
    assert_bit_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bit_q < total_q));

    // R2: an accepted start selects the flash and raises busy next cycle
    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && !busy) |=> (!spi_cs_n && busy));

    // R8: a start with no transmit bytes leaves the engine idle
    assert_zero_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && launch_tx == '0 && !busy) |=> (spi_cs_n && !busy));

    // R7: the register file never forwards a start while a transaction runs
    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !launch);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic              busy, launch, tick, rx_we;
    logic [CNT_W-1:0]  launch_tx, launch_rx;
    logic [DIV_W-1:0]  div_sel;
    logic [WORD_W-1:0] cmd_q, data_q;
    logic [1:0]        rx_idx;
    logic [7:0]        rx_byte;

    spi_cmd_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .rx_we     (rx_we),
        .rx_idx    (rx_idx),
        .rx_byte   (rx_byte),
        .launch    (launch),
        .launch_tx (launch_tx),
        .launch_rx (launch_rx),
        .div_sel   (div_sel),
        .cmd_q     (cmd_q),
        .data_q    (data_q)
    );

    spi_cmd_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .sel   (div_sel),
        .tick  (tick)
    );

    spi_cmd_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .launch_tx (launch_tx),
        .launch_rx (launch_rx),
        .snap_cmd  (cmd_q),
        .snap_data (data_q),
        .tick      (tick),
        .spi_miso  (spi_miso),
        .busy      (busy),
        .spi_cs_n  (spi_cs_n),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .rx_we     (rx_we),
        .rx_idx    (rx_idx),
        .rx_byte   (rx_byte)
    );
endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    int nchk = 0, nerr = 0;
    bit stream_b [256];
    bit capbits  [256];
    int nrise = 0, ncs = 0, bad_per = 0, miso_i = 0;
    longint last_rise = 0, exp_per = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash model: serves stream_b MSB-first, records MOSI on rising SCK
    always @(negedge spi_cs_n) begin
        if (rst_n) begin
            ncs++;
            nrise = 0;
            spi_miso = stream_b[0];
            miso_i = 1;
        end
    end
    always @(posedge spi_sck) begin
        if (nrise > 0 && (longint'($time) - last_rise) != exp_per) bad_per++;
        last_rise = longint'($time);
        if (nrise < 256) capbits[nrise] = spi_mosi;
        nrise++;
    end
    always @(negedge spi_sck) begin
        if (!spi_cs_n && miso_i < 256) begin
            spi_miso = stream_b[miso_i];
            miso_i++;
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] mk_ctrl(int tx, int rx, int dv, int sz, bit go);
        logic [31:0] w = '0;
        w[3:0] = 4'(tx); w[7:4] = 4'(rx); w[8] = go;
        w[18:17] = 2'(sz); w[25:24] = 2'(dv);
        return w;
    endfunction

    function automatic logic [7:0] exp_tx(logic [31:0] c, logic [31:0] d, int i);
        case (i)
            0: return c[7:0];
            1: return c[31:24];
            2: return c[23:16];
            3: return c[15:8];
            4: return d[7:0];
            5: return d[15:8];
            6: return d[23:16];
            7: return d[31:24];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] stream_byte(int p);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[7-k] = stream_b[p*8+k];
        return b;
    endfunction

    function automatic logic [7:0] cap_byte(int p);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[7-k] = capbits[p*8+k];
        return b;
    endfunction

    task automatic wait_idle(output int cyc);
        logic [31:0] r;
        cyc = 0;
        do begin
            @(negedge clk);
            bus_read(4'h0, r);
            cyc++;
        end while (r[16] && cyc < 5000);
    endtask

    task automatic run_txn(logic [7:0] op, logic [23:0] adr, logic [31:0] dat,
                           int tx, int rx, int dv);
        logic [31:0] r, exp_d;
        int cyc;
        for (int i = 0; i < 256; i++) stream_b[i] = bit'($urandom_range(0, 1));
        exp_per = longint'(2 * (1 << dv) * CLK_PERIOD);
        ncs = 0; bad_per = 0; nrise = 0;
        bus_write(4'h4, {adr, op});
        bus_write(4'h8, dat);
        bus_write(4'h0, mk_ctrl(tx, rx, dv, 1, 1'b1));
        bus_read(4'h0, r);
        chk("R2", "busy after start", 32'(r[16]), 32'(1));
        wait_idle(cyc);
        chk("R2", "cs released when busy clears", 32'(spi_cs_n), 32'(1));
        chk("R5", "cs falls", 32'(ncs), 32'(1));
        chk("R5", "sck rising edges", 32'(nrise), 32'(8 * (tx + rx)));
        chk("R6", "sck period violations", 32'(bad_per), 32'(0));
        for (int i = 0; i < tx + rx && i < 32; i++) begin
            if (i < tx) chk("R3", "transmit byte", 32'(cap_byte(i)), 32'(exp_tx({adr, op}, dat, i)));
            else        chk("R4", "mosi during receive", 32'(cap_byte(i)), 32'(0));
        end
        if (rx == 0) exp_d = dat;
        else begin
            exp_d = '0;
            for (int j = 0; j < 4; j++)
                if (j < rx) exp_d[8*j +: 8] = stream_byte(tx + j);
        end
        bus_read(4'h8, r);
        chk("R4", "data register", r, exp_d);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
        report();
        $finish;
    end

    initial begin
        logic [31:0] r, w;
        int cyc;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R9 / R1 reset state
        chk("R9", "cs_n at reset", 32'(spi_cs_n), 32'(1));
        chk("R9", "sck at reset", 32'(spi_sck), 32'(0));
        chk("R9", "mosi at reset", 32'(spi_mosi), 32'(0));
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(4'h0, r); chk("R1", "ctrl reset", r, 32'h0);
        bus_read(4'h4, r); chk("R1", "cmd reset",  r, 32'h0);
        bus_read(4'h8, r); chk("R1", "data reset", r, 32'h0);

        // R1 field readback, unlisted bits masked, no start
        w = 32'hFCF8_FE00 | mk_ctrl(5, 3, 1, 2, 1'b0);
        bus_write(4'h0, w);
        bus_read(4'h0, r);
        chk("R1", "ctrl readback", r, mk_ctrl(5, 3, 1, 2, 1'b0));
        chk("R5", "no transaction without start", 32'(spi_cs_n), 32'(1));
        bus_write(4'h4, 32'h1234_56AB);
        bus_read(4'h4, r); chk("R1", "cmd readback", r, 32'h1234_56AB);

        // directed transactions
        run_txn(8'hAB, 24'h000000, 32'h0, 4, 1, 0);          // signature-style read
        run_txn(8'h02, 24'hA1B2C3, 32'hD4C3B2A1, 8, 0, 1);   // full program frame
        run_txn(8'h03, 24'h123456, 32'h0, 4, 4, 2);          // full receive
        run_txn(8'h0B, 24'h654321, 32'hCAFEF00D, 11, 2, 0);  // R3 positions past eight send zero
        run_txn(8'h9F, 24'h0, 32'h0, 1, 6, 3);               // R4 extra receive bytes discarded

        // R8 zero transmit count with start
        ncs = 0;
        bus_write(4'h8, 32'h5A5A_A5A5);
        bus_write(4'h0, mk_ctrl(0, 2, 0, 0, 1'b1));
        bus_read(4'h0, r);
        chk("R8", "busy after zero-length start", 32'(r[16]), 32'(0));
        repeat (20) @(negedge clk);
        chk("R8", "cs falls", 32'(ncs), 32'(0));
        bus_read(4'h8, r);
        chk("R8", "data unchanged", r, 32'h5A5A_A5A5);

        // R7 writes while busy are ignored
        exp_per = longint'(2 * 8 * CLK_PERIOD);
        ncs = 0; bad_per = 0;
        bus_write(4'h4, 32'h00AA_BB01);
        bus_write(4'h8, 32'h1111_2222);
        bus_write(4'h0, mk_ctrl(8, 0, 3, 0, 1'b1));
        bus_write(4'h4, 32'hDEAD_BEEF);
        bus_write(4'h8, 32'h1234_5678);
        bus_write(4'h0, mk_ctrl(1, 1, 0, 0, 1'b1));
        wait_idle(cyc);
        repeat (40) @(negedge clk);
        bus_read(4'h4, r); chk("R7", "cmd kept while busy", r, 32'h00AA_BB01);
        bus_read(4'h8, r); chk("R7", "data kept while busy", r, 32'h1111_2222);
        bus_read(4'h0, r); chk("R7", "ctrl kept while busy", r, mk_ctrl(8, 0, 3, 0, 1'b0));
        chk("R7", "single transaction", 32'(ncs), 32'(1));
        chk("R6", "slowest divider period", 32'(bad_per), 32'(0));

        // constrained random transactions
        for (int n = 0; n < 40; n++) begin
            run_txn(8'($urandom), 24'($urandom), $urandom,
                    int'($urandom_range(1, 8)), int'($urandom_range(0, 5)),
                    int'($urandom_range(0, 3)));
        end

        report();
        $finish;
    end
endmodule